// File: doc/BRIEF.md
# Composite memory select generator

This block drives the active-low chip-select strobes of an external memory bus on a DSP-style processor. There are four individual strobes, one per space (program, data, boot, I/O), and one composite strobe. The composite strobe asserts whenever an individual strobe whose enable bit is set asserts, with identical timing. A designer can therefore decode one physical memory into two or more spaces with no glue logic: the composite strobe drives the memory's chip select, and one individual strobe serves as an extra address bit.

An access is started by a one-cycle request that carries the space and the address. The strobe stays asserted for a number of wait states plus one cycle, and then `acc_done` pulses. Program accesses take their wait count from the system control register. I/O accesses take theirs from one of four fields, chosen by the I/O address region. Data and boot accesses take no wait states. While the bus is granted to an external master, every strobe is held high and the access in progress is frozen.

Top module: `memsel_gen`

## Requirements
- R1: After reset every strobe is high and `acc_done` is low. The program wait and all four I/O wait fields reset to 7. The boot-disable bit resets to 0. The composite enables reset to 1 for program, data and I/O, and to 0 for boot.
- R2: Register writes (`reg_wr`=1) take effect on the next cycle. Address 0 is system control: bits 2:0 hold the program wait and bit 3 disables the boot strobe. Address 1 holds the composite enables in bits 3:0 (bit 0 program, bit 1 data, bit 2 boot, bit 3 I/O). Address 2 holds the I/O waits, 3 bits per region: region 0 in bits 2:0, region 1 in 5:3, region 2 in 8:6, region 3 in 11:9.
- R3: `req_space` encodes 0 program, 1 data, 2 boot, 3 I/O. Only the strobe of the requested space asserts, and at most one individual strobe is low at any time.
- R4: A program access holds its strobe low for (program wait + 1) cycles, beginning the cycle after the request is taken.
- R5: An I/O access holds its strobe low for (region wait + 1) cycles. The region is address bits 10:9, so the four regions are 0x000–0x1FF, 0x200–0x3FF, 0x400–0x5FF and 0x600–0x7FF.
- R6: Data and boot accesses hold their strobe low for exactly one cycle.
- R7: `acc_done` is high for exactly one cycle, in the cycle right after the strobe is released.
- R8: The composite strobe is low exactly while an individual access whose enable bit is set is in its strobe window.
- R9: With boot disable set, the boot strobe stays high, but the boot access still times out and pulses `acc_done`. It also still drives the composite strobe if the boot enable is set.
- R10: While `bus_grant` is high, all five strobes are high, a request is not taken, and an access in progress keeps its remaining count until the grant drops.
- R11: A request that arrives while an access is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle access request |
| req_space | input | 2 | Space of the request (0 program, 1 data, 2 boot, 3 I/O) |
| req_addr | input | 14 | Access address |
| bus_grant | input | 1 | Bus is granted to an external master |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 12 | Register write data |
| prog_sel_n | output | 1 | Program memory strobe, active low |
| data_sel_n | output | 1 | Data memory strobe, active low |
| boot_sel_n | output | 1 | Boot memory strobe, active low |
| io_sel_n | output | 1 | I/O strobe, active low |
| comp_sel_n | output | 1 | Composite strobe, active low |
| acc_done | output | 1 | Access-complete pulse |

## Verification
Assertions check on every cycle that at most one individual strobe is low. They also check that grant silences all five strobes, that a disabled boot strobe never falls, and that any enabled individual strobe pulls the composite strobe low. Other per-cycle checks: the done pulse is a single cycle outside any active access, the remaining count freezes during grant, and a busy access keeps its space. The strobe lengths that come from each wait field and each I/O region can only be shown by the bench's scenarios. The same goes for the reset values, the ignoring of requests made during grant or during a busy access, and the resumed count after a grant.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  localparam int NSPACE = 4;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_BOOT = 2'd2,
    SP_IO   = 2'd3
  } space_e;

  localparam logic [1:0] RA_SYS = 2'd0;
  localparam logic [1:0] RA_CEN = 2'd1;
  localparam logic [1:0] RA_IOW = 2'd2;

  localparam logic [NSPACE-1:0] CEN_RESET = 4'b1011;
endpackage

// File: rtl/memsel_regs.sv
module memsel_regs
  import memsel_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int NUM_IO = 4,
  parameter int DW     = NUM_IO * WAIT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [WAIT_W-1:0]        prog_wait,
  output logic                     boot_off,
  output logic [NSPACE-1:0]        comp_en,
  output logic [NUM_IO*WAIT_W-1:0] io_wait
);
  localparam int BOOT_OFF_BIT = WAIT_W;
  localparam int LOW_USE = (WAIT_W + 1 > NSPACE) ? WAIT_W + 1 : NSPACE;

  logic wr_sys, wr_cen, wr_iow;
  assign wr_sys = wr_en && (wr_addr == RA_SYS);
  assign wr_cen = wr_en && (wr_addr == RA_CEN);
  assign wr_iow = wr_en && (wr_addr == RA_IOW);

  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:LOW_USE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_wait <= '1;
      boot_off  <= 1'b0;
      comp_en   <= CEN_RESET;
      io_wait   <= '1;
    end else begin
      if (wr_sys) begin
        prog_wait <= wr_data[WAIT_W-1:0];
        boot_off  <= wr_data[BOOT_OFF_BIT];
      end
      if (wr_cen) comp_en <= wr_data[NSPACE-1:0];
      if (wr_iow) io_wait <= wr_data[NUM_IO*WAIT_W-1:0];
    end
  end

  // R2: a write lands one cycle later
  p_cen_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cen |=> comp_en == $past(wr_data[NSPACE-1:0]));
  p_sys_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sys |=> boot_off == $past(wr_data[BOOT_OFF_BIT]));
endmodule

// File: rtl/memsel_wait_pick.sv
module memsel_wait_pick
  import memsel_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int NUM_IO = 4,
  parameter int ADDR_W = 14,
  parameter int IO_AW  = 11
) (
  input  logic [1:0]               space,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WAIT_W-1:0]        prog_wait,
  input  logic [NUM_IO*WAIT_W-1:0] io_wait,
  output logic [WAIT_W-1:0]        wait_val
);
  localparam int RB = $clog2(NUM_IO);

  logic [RB-1:0] io_region;
  assign io_region = addr[IO_AW-1 -: RB];

  logic unused_addr;
  assign unused_addr = ^{addr[ADDR_W-1:IO_AW], addr[IO_AW-RB-1:0]};

  function automatic logic [WAIT_W-1:0] pick_wait(
    input logic [1:0]               sp,
    input logic [RB-1:0]            reg_i,
    input logic [WAIT_W-1:0]        pw,
    input logic [NUM_IO*WAIT_W-1:0] iw
  );
    logic [WAIT_W-1:0] r;
    case (space_e'(sp))
      SP_PROG: r = pw;
      SP_IO:   r = iw[reg_i*WAIT_W +: WAIT_W];
      default: r = '0;
    endcase
    return r;
  endfunction

  assign wait_val = pick_wait(space, io_region, prog_wait, io_wait);
endmodule

// File: rtl/memsel_seq.sv
module memsel_seq #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_space,
  input  logic [WAIT_W-1:0] wait_in,
  input  logic              hold,
  output logic              active,
  output logic [1:0]        space_q,
  output logic              acc_done
);
  logic [WAIT_W-1:0] cnt;
  logic start_evt, finish_evt, tick_evt;

  assign start_evt  = req_valid && !active && !hold;
  assign finish_evt = active && !hold && (cnt == '0);
  assign tick_evt   = active && !hold && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      space_q  <= '0;
      cnt      <= '0;
      acc_done <= 1'b0;
    end else begin
      acc_done <= finish_evt;
      if (start_evt) begin
        active  <= 1'b1;
        space_q <= req_space;
        cnt     <= wait_in;
      end else if (finish_evt) begin
        active <= 1'b0;
      end else if (tick_evt) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> !active);
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold) |=> (active && cnt == $past(cnt)));
  p_busy_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !finish_evt) |=> (active && space_q == $past(space_q)));
endmodule

// File: rtl/memsel_strobes.sv
module memsel_strobes
  import memsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [1:0]        space_q,
  input  logic              hold,
  input  logic              boot_off,
  input  logic [NSPACE-1:0] comp_en,
  output logic [NSPACE-1:0] sel_n,
  output logic              comp_n
);
  logic [NSPACE-1:0] raw_sel;

  for (genvar i = 0; i < NSPACE; i++) begin : g_space
    assign raw_sel[i] = active && !hold && (space_q == i);
    if (i == int'(SP_BOOT)) begin : g_boot
      assign sel_n[i] = !(raw_sel[i] && !boot_off);
    end else begin : g_plain
      assign sel_n[i] = !raw_sel[i];
    end
    p_comp_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n[i] && comp_en[i]) |-> !comp_n);
  end

  assign comp_n = !(|(raw_sel & comp_en));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (&sel_n && comp_n));
  p_boot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_off |-> sel_n[SP_BOOT]);
  p_comp_only_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_n |-> active);
endmodule

// File: rtl/memsel_gen.sv
module memsel_gen
  import memsel_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int NUM_IO = 4,
  parameter int ADDR_W = 14,
  parameter int IO_AW  = 11,
  localparam int DW    = NUM_IO * WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              bus_grant,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic              prog_sel_n,
  output logic              data_sel_n,
  output logic              boot_sel_n,
  output logic              io_sel_n,
  output logic              comp_sel_n,
  output logic              acc_done
);
  logic [WAIT_W-1:0]        prog_wait;
  logic                     boot_off;
  logic [NSPACE-1:0]        comp_en;
  logic [NUM_IO*WAIT_W-1:0] io_wait;
  logic [WAIT_W-1:0]        wait_val;
  logic                     active;
  logic [1:0]               space_q;
  logic [NSPACE-1:0]        sel_n;

  memsel_regs #(.WAIT_W(WAIT_W), .NUM_IO(NUM_IO), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .prog_wait(prog_wait), .boot_off(boot_off),
    .comp_en(comp_en), .io_wait(io_wait)
  );

  memsel_wait_pick #(.WAIT_W(WAIT_W), .NUM_IO(NUM_IO), .ADDR_W(ADDR_W),
                     .IO_AW(IO_AW)) u_pick (
    .space(req_space), .addr(req_addr), .prog_wait(prog_wait),
    .io_wait(io_wait), .wait_val(wait_val)
  );

  memsel_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .wait_in(wait_val), .hold(bus_grant), .active(active),
    .space_q(space_q), .acc_done(acc_done)
  );

  memsel_strobes u_strb (
    .clk(clk), .rst_n(rst_n), .active(active), .space_q(space_q),
    .hold(bus_grant), .boot_off(boot_off), .comp_en(comp_en),
    .sel_n(sel_n), .comp_n(comp_sel_n)
  );

  assign prog_sel_n = sel_n[SP_PROG];
  assign data_sel_n = sel_n[SP_DATA];
  assign boot_sel_n = sel_n[SP_BOOT];
  assign io_sel_n   = sel_n[SP_IO];
endmodule

// File: tb/test_memsel_gen.sv
module test_memsel_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_space = '0;
  logic [13:0] req_addr = '0;
  logic bus_grant = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic prog_sel_n, data_sel_n, boot_sel_n, io_sel_n, comp_sel_n, acc_done;

  int n_tests = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  memsel_gen i_memsel_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_addr(req_addr), .bus_grant(bus_grant), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .prog_sel_n(prog_sel_n),
    .data_sel_n(data_sel_n), .boot_sel_n(boot_sel_n), .io_sel_n(io_sel_n),
    .comp_sel_n(comp_sel_n), .acc_done(acc_done)
  );

  function automatic logic [3:0] lows();
    return ~{io_sel_n, boot_sel_n, data_sel_n, prog_sel_n};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [11:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Requests an access and checks strobes for len cycles, then done.
  task automatic access(input int sp, input int addr, input int len,
                        input logic [3:0] exp_low, input logic exp_comp,
                        input string rq);
    req_valid = 1'b1; req_space = 2'(sp); req_addr = 14'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk(lows() == exp_low, rq, "strobes in window", int'(lows()), int'(exp_low));
      chk(comp_sel_n == !exp_comp, rq, "composite in window",
          int'(comp_sel_n), int'(!exp_comp));
      chk(!acc_done, rq, "done early", int'(acc_done), 0);
      @(negedge clk);
    end
    chk(lows() == 4'b0 && comp_sel_n, rq, "strobes released",
        int'({comp_sel_n, lows()}), 16);
    chk(acc_done, rq, "done pulse", int'(acc_done), 1);
    @(negedge clk);
    chk(!acc_done, rq, "done one cycle", int'(acc_done), 0);
  endtask

  task automatic t_reset();
    chk(lows() == 4'b0 && comp_sel_n && !acc_done, "R1", "reset outputs",
        int'({acc_done, comp_sel_n, lows()}), 16);
    // reset program wait 7 -> 8 cycles, program enabled in composite
    access(0, 0, 8, 4'b0001, 1'b1, "R1");
    // reset boot enable 0 -> composite stays high
    access(2, 0, 1, 4'b0100, 1'b0, "R1");
  endtask

  task automatic t_prog();
    wr_reg(2'd0, 12'h002);
    access(0, 12, 3, 4'b0001, 1'b1, "R4");
    wr_reg(2'd0, 12'h000);
    access(0, 12, 1, 4'b0001, 1'b1, "R4");
  endtask

  task automatic t_io();
    wr_reg(2'd2, 12'(1 | (4 << 3) | (0 << 6) | (6 << 9)));
    access(3, 'h100, 2, 4'b1000, 1'b1, "R5");
    access(3, 'h2AB, 5, 4'b1000, 1'b1, "R5");
    access(3, 'h400, 1, 4'b1000, 1'b1, "R5");
    access(3, 'h7FF, 7, 4'b1000, 1'b1, "R5");
  endtask

  task automatic t_data_boot();
    wr_reg(2'd0, 12'h005);
    access(1, 'h33, 1, 4'b0010, 1'b1, "R6");
    access(2, 'h33, 1, 4'b0100, 1'b0, "R6");
    access(1, 'h33, 1, 4'b0010, 1'b1, "R3");
  endtask

  task automatic t_composite();
    wr_reg(2'd1, 12'b0110);
    access(0, 0, 6, 4'b0001, 1'b0, "R8");
    access(1, 0, 1, 4'b0010, 1'b1, "R8");
    access(2, 0, 1, 4'b0100, 1'b1, "R8");
    access(3, 'h100, 2, 4'b1000, 1'b0, "R8");
    wr_reg(2'd1, 12'b1011);
  endtask

  task automatic t_boot_off();
    wr_reg(2'd0, 12'h008);
    wr_reg(2'd1, 12'b0100);
    access(2, 0, 1, 4'b0000, 1'b1, "R9");
    wr_reg(2'd1, 12'b0000);
    access(2, 0, 1, 4'b0000, 1'b0, "R9");
    wr_reg(2'd0, 12'h000);
    wr_reg(2'd1, 12'b1011);
  endtask

  task automatic t_grant();
    wr_reg(2'd0, 12'h002);
    // request while granted is not taken
    bus_grant = 1'b1;
    req_valid = 1'b1; req_space = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    bus_grant = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(lows() == 4'b0 && !acc_done, "R10", "request under grant ignored",
          int'({acc_done, lows()}), 0);
      @(negedge clk);
    end
    // grant in the middle of a 3-cycle program access
    req_valid = 1'b1; req_space = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(lows() == 4'b0001, "R10", "window start", int'(lows()), 1);
    bus_grant = 1'b1;
    @(negedge clk);
    chk(lows() == 4'b0 && comp_sel_n, "R10", "quiet under grant",
        int'({comp_sel_n, lows()}), 16);
    @(negedge clk);
    chk(lows() == 4'b0 && comp_sel_n && !acc_done, "R10", "still quiet",
        int'({acc_done, comp_sel_n, lows()}), 16);
    bus_grant = 1'b0;
    @(negedge clk);
    chk(lows() == 4'b0001, "R10", "resumed 1", int'(lows()), 1);
    @(negedge clk);
    chk(lows() == 4'b0001, "R10", "resumed 2", int'(lows()), 1);
    @(negedge clk);
    chk(lows() == 4'b0 && acc_done, "R10", "done after resume",
        int'({acc_done, lows()}), 16);
    @(negedge clk);
  endtask

  task automatic t_busy();
    wr_reg(2'd0, 12'h003);
    req_valid = 1'b1; req_space = 2'd0;
    @(negedge clk);
    req_valid = 1'b1; req_space = 2'd1;
    chk(lows() == 4'b0001, "R11", "first window", int'(lows()), 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k < 4; k++) begin
      chk(lows() == 4'b0001, "R11", "busy request ignored", int'(lows()), 1);
      @(negedge clk);
    end
    chk(lows() == 4'b0 && acc_done, "R11", "end of first access",
        int'({acc_done, lows()}), 16);
    @(negedge clk);
    chk(lows() == 4'b0 && !acc_done, "R11", "no second access",
        int'({acc_done, lows()}), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog();
    t_io();
    t_data_boot();
    t_composite();
    t_boot_off();
    t_grant();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule